// File: doc/BRIEF.md
# Receiver Power-Up Sequencer and Mode Controller

This block is the digital control core of a radio receiver. The analog sections, the demodulators, the slicer comparator and the output noise filter sit outside it and appear here only as enable and select lines. When the receive enable rises, the block first powers the bias network and the reference oscillator. It then waits for the oscillator to report that its amplitude is good. Next it powers the rest of the receiver and holds the baseband capacitors in pre-charge for a fixed number of reference-clock cycles. After that it drives the data pin.

The block also turns the static mode straps into switch settings. These straps select the modulation type, the slicer threshold method, which low-noise amplifier runs, and whether the noise filter is present. The peak-detector bias switches change with both the slicer mode and the power state, so the hold capacitors start from known rails. When the receive enable falls, the block drops back to shutdown from any state.

Top module: `rxseq_ctrl`

## Requirements
- R1: While reset is asserted, and in shutdown, every section enable, the pre-charge line, the data output enable, the baseband pin drive, the noise-filter bypass and the done flag are all 0.
- R2: The first power state after enable reaches the core drives only the bias and oscillator enables (`bias_en_o`, `osc_en_o`) high. The core, both amplifiers, the FSK demodulator and the data output stay low until `osc_ok_i` is seen, however long that takes.
- R3: After `osc_ok_i` is seen, `core_en_o`, `dpath_drive_o` and `precharge_o` go high together.
- R4: `precharge_o` stays high for exactly PRECHARGE_CYCLES (default 5504) clock cycles. In the cycle after it falls, `data_oe_o` and `done_o` go to 1 and stay there.
- R5: `nf_gnd_i` is sampled once, when pre-charge starts. A sampled 1 sets `nf_bypass_o` to 1, which routes the slicer straight to the data pin. Later changes to the pin have no effect until the next start-up, and shutdown clears the bypass.
- R6: `dfilt_fsk_o` follows `mod_fsk_i`: 0 selects the RSSI (ASK) path and 1 selects the FSK demodulator. `fsk_dem_en_o` is 1 only when the core is powered and `mod_fsk_i` is 1.
- R7: With `slc_peak_i` = 0 (averaging), in every state: `pkdet_en_o` = 0, `pdp_gnd_o` = 1, `pdn_gnd_o` = 1 and `pdn_vcc_o` = 0.
- R8: With `slc_peak_i` = 1 and the core unpowered: `pkdet_en_o` = 0, `pdp_gnd_o` = 1, `pdn_vcc_o` = 1 and `pdn_gnd_o` = 0. With the core powered: `pkdet_en_o` = 1 and all three switches are open.
- R9: With the core powered, `lna_sel_i` 2'b00 enables only amplifier 1, 2'b01 enables only amplifier 2, and 2'b1x (the mid-level strap) enables both. Both are off while the core is unpowered.
- R10: A fall of the synchronized enable returns the block to shutdown on the next edge from any state. The pre-charge count restarts from zero on the next start-up.
- R11: `rx_en_i` and `osc_ok_i` each pass through two flops. A change applied before clock edge k first shows in the power state after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receive enable (0 shutdown, 1 receive), asynchronous |
| osc_ok_i | input | 1 | Oscillator amplitude-good flag, asynchronous |
| mod_fsk_i | input | 1 | Modulation strap: 0 ASK, 1 FSK |
| slc_peak_i | input | 1 | Slicer strap: 0 averaging, 1 peak detection |
| lna_sel_i | input | 2 | Amplifier strap: 00 first, 01 second, 1x both |
| nf_gnd_i | input | 1 | 1 when the noise-filter integrator pin is tied to ground |
| bias_en_o | output | 1 | Bias network enable |
| osc_en_o | output | 1 | Reference oscillator enable |
| core_en_o | output | 1 | Enable for the remaining receiver sections |
| lna1_en_o | output | 1 | First low-noise amplifier enable |
| lna2_en_o | output | 1 | Second low-noise amplifier enable |
| fsk_dem_en_o | output | 1 | FSK demodulator enable |
| dfilt_fsk_o | output | 1 | Data-filter input switch: 1 FSK demodulator, 0 RSSI |
| precharge_o | output | 1 | Capacitor pre-charge active |
| pkdet_en_o | output | 1 | Peak detector enable |
| pdp_gnd_o | output | 1 | Positive-peak output to negative rail switch |
| pdn_gnd_o | output | 1 | Negative-peak output to negative rail switch |
| pdn_vcc_o | output | 1 | Negative-peak output to positive rail switch |
| nf_bypass_o | output | 1 | Output mux: 1 slicer direct, 0 through noise filter |
| data_oe_o | output | 1 | Data pin output enable |
| dpath_drive_o | output | 1 | Filter and slicer pins driven (0 floating) |
| done_o | output | 1 | Start-up complete |

## Verification
On every cycle, the assertions check these properties. The block enters the run state only from the last pre-charge count. The counter stays within range. A low synchronized enable forces shutdown. The first step out of shutdown is the oscillator-only state. The negative-peak output is never tied to both rails. An enabled peak detector never has a closed bias switch. A powered core always has at least one amplifier running. Only the bench's scenarios can show the rest: the exact 5504-cycle pre-charge length, the two-flop latency on both asynchronous inputs, and the one-time sampling of the noise-filter strap. They also show that an aborted sequence restarts its count, and they cover the full mix of strap settings.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_OSC = 2'd1,
        ST_PRE = 2'd2,
        ST_RUN = 2'd3
    } seq_state_e;

    localparam logic [1:0] LNA_ONLY_FIRST  = 2'b00;
    localparam logic [1:0] LNA_ONLY_SECOND = 2'b01;
endpackage

// File: rtl/rxseq_sync.sv
module rxseq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rxseq_fsm.sv
module rxseq_fsm
    import rxseq_pkg::*;
#(
    parameter int PRECHARGE_CYCLES = 5504
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       osc_ok_i,
    input  logic       nf_gnd_i,
    output seq_state_e state_o,
    output logic       bypass_o
);
    localparam int CW = (PRECHARGE_CYCLES > 1) ? $clog2(PRECHARGE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRECHARGE_CYCLES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          bypass;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!en_i) begin
            r_d.state  = ST_OFF;
            r_d.cnt    = '0;
            r_d.bypass = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_OFF: r_d.state = ST_OSC;
                ST_OSC: begin
                    if (osc_ok_i) begin
                        r_d.state  = ST_PRE;
                        r_d.cnt    = '0;
                        r_d.bypass = nf_gnd_i;
                    end
                end
                ST_PRE: begin
                    if (r_q.cnt == LAST) begin
                        r_d.state = ST_RUN;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: r_d.state = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{state: ST_OFF, cnt: '0, bypass: 1'b0};
        else         r_q <= r_d;
    end

    assign state_o  = r_q.state;
    assign bypass_o = r_q.bypass;

    // R4
    run_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_RUN && $past(r_q.state) != ST_RUN)
        |-> ($past(r_q.state) == ST_PRE && $past(r_q.cnt) == LAST));

    // R4
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.cnt <= LAST);

    // R10
    abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (r_q.state == ST_OFF && r_q.cnt == '0));

    // R2
    osc_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(r_q.state) == ST_OFF && r_q.state != ST_OFF) |-> r_q.state == ST_OSC);
endmodule

// File: rtl/rxseq_switch.sv
module rxseq_switch
    import rxseq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       core_on_i,
    input  logic       mod_fsk_i,
    input  logic       slc_peak_i,
    input  logic [1:0] lna_sel_i,
    output logic       lna1_en_o,
    output logic       lna2_en_o,
    output logic       fsk_dem_en_o,
    output logic       dfilt_fsk_o,
    output logic       pkdet_en_o,
    output logic       pdp_gnd_o,
    output logic       pdn_gnd_o,
    output logic       pdn_vcc_o
);
    always_comb begin
        lna1_en_o = 1'b0;
        lna2_en_o = 1'b0;
        if (core_on_i) begin
            unique case (lna_sel_i)
                LNA_ONLY_FIRST:  lna1_en_o = 1'b1;
                LNA_ONLY_SECOND: lna2_en_o = 1'b1;
                default: begin
                    lna1_en_o = 1'b1;
                    lna2_en_o = 1'b1;
                end
            endcase
        end
    end

    assign dfilt_fsk_o  = mod_fsk_i;
    assign fsk_dem_en_o = core_on_i & mod_fsk_i;

    always_comb begin
        pkdet_en_o = 1'b0;
        pdp_gnd_o  = 1'b1;
        pdn_gnd_o  = 1'b0;
        pdn_vcc_o  = 1'b0;
        if (!slc_peak_i) begin
            pdn_gnd_o = 1'b1;
        end else if (!core_on_i) begin
            pdn_vcc_o = 1'b1;
        end else begin
            pkdet_en_o = 1'b1;
            pdp_gnd_o  = 1'b0;
        end
    end

    // R8
    rail_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pdn_gnd_o && pdn_vcc_o));

    // R8
    pkdet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkdet_en_o |-> !(pdp_gnd_o || pdn_gnd_o || pdn_vcc_o));

    // R9
    lna_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_on_i |-> (lna1_en_o || lna2_en_o));
endmodule

// File: rtl/rxseq_ctrl.sv
module rxseq_ctrl
    import rxseq_pkg::*;
#(
    parameter int PRECHARGE_CYCLES = 5504,
    parameter int SYNC_STAGES      = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rx_en_i,
    input  logic       osc_ok_i,
    input  logic       mod_fsk_i,
    input  logic       slc_peak_i,
    input  logic [1:0] lna_sel_i,
    input  logic       nf_gnd_i,
    output logic       bias_en_o,
    output logic       osc_en_o,
    output logic       core_en_o,
    output logic       lna1_en_o,
    output logic       lna2_en_o,
    output logic       fsk_dem_en_o,
    output logic       dfilt_fsk_o,
    output logic       precharge_o,
    output logic       pkdet_en_o,
    output logic       pdp_gnd_o,
    output logic       pdn_gnd_o,
    output logic       pdn_vcc_o,
    output logic       nf_bypass_o,
    output logic       data_oe_o,
    output logic       dpath_drive_o,
    output logic       done_o
);
    logic [1:0] sync_s;
    seq_state_e state_s;
    logic       core_on_s;

    rxseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({osc_ok_i, rx_en_i}),
        .sync_o  (sync_s)
    );

    rxseq_fsm #(.PRECHARGE_CYCLES(PRECHARGE_CYCLES)) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (sync_s[0]),
        .osc_ok_i (sync_s[1]),
        .nf_gnd_i (nf_gnd_i),
        .state_o  (state_s),
        .bypass_o (nf_bypass_o)
    );

    assign core_on_s     = (state_s == ST_PRE) || (state_s == ST_RUN);
    assign bias_en_o     = (state_s != ST_OFF);
    assign osc_en_o      = (state_s != ST_OFF);
    assign core_en_o     = core_on_s;
    assign dpath_drive_o = core_on_s;
    assign precharge_o   = (state_s == ST_PRE);
    assign data_oe_o     = (state_s == ST_RUN);
    assign done_o        = (state_s == ST_RUN);

    rxseq_switch u_switch (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .core_on_i    (core_on_s),
        .mod_fsk_i    (mod_fsk_i),
        .slc_peak_i   (slc_peak_i),
        .lna_sel_i    (lna_sel_i),
        .lna1_en_o    (lna1_en_o),
        .lna2_en_o    (lna2_en_o),
        .fsk_dem_en_o (fsk_dem_en_o),
        .dfilt_fsk_o  (dfilt_fsk_o),
        .pkdet_en_o   (pkdet_en_o),
        .pdp_gnd_o    (pdp_gnd_o),
        .pdn_gnd_o    (pdn_gnd_o),
        .pdn_vcc_o    (pdn_vcc_o)
    );
endmodule

// File: tb/rxseq_ctrl_bench.sv
module rxseq_ctrl_bench;
    localparam int PRE_N = 5504;

    logic clk = 1'b0;
    logic rst_n;
    logic rx_en, osc_ok, mod_fsk, slc_peak, nf_gnd;
    logic [1:0] lna_sel;
    logic bias_en, osc_en, core_en, lna1_en, lna2_en, fsk_dem_en, dfilt_fsk;
    logic precharge, pkdet_en, pdp_gnd, pdn_gnd, pdn_vcc, nf_bypass;
    logic data_oe, dpath_drive, done;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    rxseq_ctrl u_rxseq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .osc_ok_i(osc_ok),
        .mod_fsk_i(mod_fsk), .slc_peak_i(slc_peak), .lna_sel_i(lna_sel),
        .nf_gnd_i(nf_gnd), .bias_en_o(bias_en), .osc_en_o(osc_en),
        .core_en_o(core_en), .lna1_en_o(lna1_en), .lna2_en_o(lna2_en),
        .fsk_dem_en_o(fsk_dem_en), .dfilt_fsk_o(dfilt_fsk),
        .precharge_o(precharge), .pkdet_en_o(pkdet_en), .pdp_gnd_o(pdp_gnd),
        .pdn_gnd_o(pdn_gnd), .pdn_vcc_o(pdn_vcc), .nf_bypass_o(nf_bypass),
        .data_oe_o(data_oe), .dpath_drive_o(dpath_drive), .done_o(done)
    );

    // {mod, slc, lna[1:0], lna1, lna2, dem, pk, pdp_gnd, pdn_gnd, pdn_vcc}, core powered
    localparam int NV = 6;
    localparam logic [10:0] VEC [NV] = '{
        11'b0_0_00_1_0_0_0_1_1_0,
        11'b1_0_01_0_1_1_0_1_1_0,
        11'b0_1_10_1_1_0_1_0_0_0,
        11'b1_1_11_1_1_1_1_0_0_0,
        11'b1_1_00_1_0_1_1_0_0_0,
        11'b0_1_01_0_1_0_1_0_0_0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_pre(input string tag, input logic flip_nf, output int n);
        n = 0;
        while (precharge === 1'b1 && n < 20000) begin
            n++;
            if (flip_nf && n == 50) nf_gnd = ~nf_gnd;
            tick(1);
        end
    endtask

    initial begin
        int n;
        rst_n = 1'b0; rx_en = 1'b0; osc_ok = 1'b0; mod_fsk = 1'b0;
        slc_peak = 1'b0; nf_gnd = 1'b0; lna_sel = 2'b00;
        tick(3);
        // R1 reset state
        chk("R1 bias", {bias_en, osc_en, core_en}, 3'b000);
        chk("R1 out", {data_oe, done, dpath_drive, precharge, nf_bypass}, 5'b0);
        chk("R1 lna", {lna1_en, lna2_en, fsk_dem_en}, 3'b000);
        // R7 averaging in shutdown
        chk("R7 off", {pkdet_en, pdp_gnd, pdn_gnd, pdn_vcc}, 4'b0110);
        rst_n = 1'b1;
        tick(2);
        slc_peak = 1'b1;
        #1;
        // R8 peak strap in shutdown
        chk("R8 off", {pkdet_en, pdp_gnd, pdn_gnd, pdn_vcc}, 4'b0101);

        tick(1);
        rx_en = 1'b1; nf_gnd = 1'b1; mod_fsk = 1'b1;
        tick(2);
        chk("R11 en latency", {bias_en, osc_en}, 2'b00);
        tick(1);
        chk("R2 osc only", {bias_en, osc_en, core_en}, 3'b110);
        chk("R2 rest off", {lna1_en, lna2_en, fsk_dem_en, data_oe, precharge}, 5'b0);
        chk("R8 osc state", {pkdet_en, pdp_gnd, pdn_gnd, pdn_vcc}, 4'b0101);
        tick(20);
        chk("R2 waits osc_ok", {osc_en, core_en}, 2'b10);

        osc_ok = 1'b1;
        tick(2);
        chk("R11 ok latency", core_en, 1'b0);
        tick(1);
        chk("R3 core up", {core_en, dpath_drive, precharge, data_oe}, 4'b1110);
        chk("R5 bypass set", nf_bypass, 1'b1);
        chk("R8 peak active", {pkdet_en, pdp_gnd, pdn_gnd, pdn_vcc}, 4'b1000);
        chk("R6 demod on", {fsk_dem_en, dfilt_fsk}, 2'b11);
        measure_pre("R4", 1'b1, n);
        chk("R4 precharge length", n, PRE_N);
        chk("R4 release", {data_oe, done, precharge}, 3'b110);
        chk("R5 held after pin change", nf_bypass, 1'b1);

        // R6 R7 R8 R9 strap table with core powered
        for (int i = 0; i < NV; i++) begin
            {mod_fsk, slc_peak, lna_sel} = VEC[i][10:7];
            #1;
            chk("R9 lna", {lna1_en, lna2_en}, VEC[i][6:5]);
            chk("R6 demod", {fsk_dem_en, dfilt_fsk}, {VEC[i][4], VEC[i][10]});
            chk("R7 R8 slicer", {pkdet_en, pdp_gnd, pdn_gnd, pdn_vcc}, VEC[i][3:0]);
            tick(1);
        end

        // R10 abort from run
        rx_en = 1'b0;
        tick(2);
        chk("R11 fall latency", data_oe, 1'b1);
        tick(1);
        chk("R10 shutdown", {bias_en, core_en, data_oe, done, dpath_drive}, 5'b0);
        chk("R5 bypass cleared", nf_bypass, 1'b0);
        mod_fsk = 1'b1; lna_sel = 2'b10;
        #1;
        chk("R9 lna off", {lna1_en, lna2_en, fsk_dem_en}, 3'b000);

        // second start-up, strap low, aborted mid pre-charge
        slc_peak = 1'b0; nf_gnd = 1'b0; rx_en = 1'b1;
        n = 0;
        while (precharge !== 1'b1 && n < 100) begin n++; tick(1); end
        chk("R5 bypass clear", nf_bypass, 1'b0);
        chk("R7 run averaging", {pkdet_en, pdp_gnd, pdn_gnd, pdn_vcc}, 4'b0110);
        tick(100);
        rx_en = 1'b0;
        tick(3);
        chk("R10 abort precharge", {precharge, core_en, osc_en}, 3'b000);
        rx_en = 1'b1;
        n = 0;
        while (precharge !== 1'b1 && n < 100) begin n++; tick(1); end
        measure_pre("R10", 1'b0, n);
        chk("R10 count restarted", n, PRE_N);
        chk("R4 release again", data_oe, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule